// File: doc/BRIEF.md
# Change-Only Trace Recorder with Timestamps

This block captures a wide parallel input bus into an on-chip trace memory, but writes a record only when a watched channel changes. Quiet stretches cost no storage, so a fixed-depth buffer can cover a long span of time when the inputs move slowly. Each stored record holds the full bus state and, in a parallel field, the value of a free-running timestamp counter. Elapsed time between sparse records can therefore be rebuilt afterwards.

Each channel has its own two-bit detection rule. The bus is divided into equal groups, and each group has its own sample strobe, so the groups can be captured under independent sampling schemes. A trace controller drives the enable. The rising edge of that enable arms a new capture run: the buffer restarts at address zero and the first strobed sample is stored unconditionally as a reference. When the timestamp counter reaches its top value, a record is forced so that no wrap of time goes unseen. Recording stops once the buffer is full. The controller reads records through a registered read port and watches the write pointer, the record count and the full flag.

Top module: `trc_change_rec`

## Requirements
- R1: When `rec_en` rises, the write pointer and record count restart at zero, and the first cycle with any `smp_vld` bit set is stored as a reference record whatever the detection rules say.
- R2: Channel c takes its rule from `det_cfg[2c+1:2c]`: 2'b00 never causes a store, 2'b01 stores on any change, 2'b10 stores only on a 0-to-1 change, and 2'b11 stores only on a 1-to-0 change.
- R3: A record holds the complete merged bus state after the sample (the new values of the strobed groups and the held values of all others), together with the timestamp.
- R4: Group g covers bits `[g*CH/NGRP +: CH/NGRP]` and is sampled only when `smp_vld[g]` is high. An unstrobed group keeps its previous value and cannot cause a store.
- R5: The timestamp counter starts at 0 after reset, advances by 1 every clock and wraps at 2^TS_W. A record carries the counter value of the cycle in which it was written.
- R6: In a cycle where the counter is at its top value, capture is enabled, the reference has been taken and the buffer is not full, a record with the held state is forced. If a change store falls in that same cycle, exactly one record is written.
- R7: While `rec_en` is low, no record is written and the record count does not change.
- R8: Once `rec_cnt` reaches DEPTH, `full` is high and further stores are dropped until the next arm.
- R9: `rd_data` and `rd_ts` show the record at `rd_addr` one clock after the address is presented.
- R10: After reset, `rec_cnt` is 0, `wr_ptr` is 0 and `full` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_en | input | 1 | Capture enable from the trace controller; its rising edge arms a new run |
| smp_vld | input | NGRP | Per-group sample strobe |
| smp_data | input | CH | Sampled input bus |
| det_cfg | input | 2*CH | Per-channel detection rule, two bits per channel |
| rd_addr | input | log2(DEPTH) | Read address |
| rd_data | output | CH | Stored bus state at the read address (one-cycle latency) |
| rd_ts | output | TS_W | Stored timestamp at the read address (one-cycle latency) |
| wr_ptr | output | log2(DEPTH) | Next write address |
| rec_cnt | output | log2(DEPTH)+1 | Number of records stored in the current run |
| full | output | 1 | Buffer holds DEPTH records |

## Verification
The change store and the forced store at the counter's top value can fall in the same cycle. A double write there would consume two entries, and a dropped change would lose data. The bench tracks the timestamp in its own model, holds back a strobe that carries a real change until the counter is about to reach its top value, and issues it then. It then expects exactly one new record, holding the changed state and the top timestamp. Long quiet stretches with capture enabled also check that forced records alone appear once per counter period.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [1:0] {
    DET_OFF  = 2'b00,
    DET_ANY  = 2'b01,
    DET_RISE = 2'b10,
    DET_FALL = 2'b11
  } det_e;
endpackage

// File: rtl/trc_detect.sv
module trc_detect
  import trc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]   prev,
  input  logic [W-1:0]   cur,
  input  logic [2*W-1:0] cfg,
  output logic           hit
);
  logic [W-1:0] ch_hit;

  for (genvar c = 0; c < W; c++) begin : g_ch
    det_e rule;
    assign rule = det_e'(cfg[2*c +: 2]);
    always_comb begin
      unique case (rule)
        DET_ANY:  ch_hit[c] = prev[c] ^ cur[c];
        DET_RISE: ch_hit[c] = ~prev[c] & cur[c];
        DET_FALL: ch_hit[c] = prev[c] & ~cur[c];
        default:  ch_hit[c] = 1'b0;
      endcase
    end
  end

  assign hit = |ch_hit;
endmodule

// File: rtl/trc_tstamp.sv
module trc_tstamp #(
  parameter int TS_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TS_W-1:0] ts,
  output logic            at_top
);
  always_ff @(posedge clk) begin
    if (rst) ts <= '0;
    else     ts <= ts + 1'b1;
  end

  assign at_top = &ts;
endmodule

// File: rtl/trc_store.sv
module trc_store #(
  parameter int DW    = 24,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/trc_change_rec.sv
module trc_change_rec
  import trc_pkg::*;
#(
  parameter int CH    = 16,
  parameter int NGRP  = 2,
  parameter int DEPTH = 32,
  parameter int TS_W  = 8,
  localparam int GW   = CH / NGRP,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1,
  localparam int DW   = CH + TS_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rec_en,
  input  logic [NGRP-1:0] smp_vld,
  input  logic [CH-1:0]   smp_data,
  input  logic [2*CH-1:0] det_cfg,
  input  logic [AW-1:0]   rd_addr,
  output logic [CH-1:0]   rd_data,
  output logic [TS_W-1:0] rd_ts,
  output logic [AW-1:0]   wr_ptr,
  output logic [CW-1:0]   rec_cnt,
  output logic            full
);
  logic            en_q;
  logic            ref_done;
  logic            full_q;
  logic [AW-1:0]   ptr_q;
  logic [CW-1:0]   cnt_q;
  logic [CH-1:0]   held_q;
  logic [CH-1:0]   merged;
  logic [NGRP-1:0] grp_hit;
  logic [TS_W-1:0] ts;
  logic            ts_top;

  // group-wise change detection and merge of strobed slices
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic hit;
    trc_detect #(.W(GW)) u_det (
      .prev (held_q[g*GW +: GW]),
      .cur  (smp_data[g*GW +: GW]),
      .cfg  (det_cfg[2*g*GW +: 2*GW]),
      .hit  (hit)
    );
    assign grp_hit[g]          = smp_vld[g] & hit;
    assign merged[g*GW +: GW]  = smp_vld[g] ? smp_data[g*GW +: GW] : held_q[g*GW +: GW];
  end

  trc_tstamp #(.TS_W(TS_W)) u_ts (
    .clk    (clk),
    .rst    (rst),
    .ts     (ts),
    .at_top (ts_top)
  );

  logic          arm;
  logic          any_vld;
  logic          room;
  logic          wr_now;
  logic [AW-1:0] base_ptr;
  logic [CW-1:0] base_cnt;
  logic [CW-1:0] next_cnt;

  always_comb begin
    arm      = rec_en & ~en_q;
    any_vld  = |smp_vld;
    base_ptr = arm ? '0 : ptr_q;
    base_cnt = arm ? '0 : cnt_q;
    room     = arm | ~full_q;
    wr_now   = rec_en & room &
               ((any_vld & (~ref_done | (|grp_hit))) | (ts_top & ref_done));
    next_cnt = base_cnt + CW'(wr_now);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      ref_done <= 1'b0;
      ptr_q    <= '0;
      cnt_q    <= '0;
      full_q   <= 1'b0;
      held_q   <= '0;
    end else begin
      en_q     <= rec_en;
      ref_done <= rec_en & (ref_done | any_vld);
      ptr_q    <= wr_now ? base_ptr + 1'b1 : base_ptr;
      cnt_q    <= next_cnt;
      full_q   <= (next_cnt == CW'(DEPTH));
      held_q   <= merged;
    end
  end

  logic [DW-1:0] rd_word;

  trc_store #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (wr_now),
    .waddr (base_ptr),
    .wdata ({merged, ts}),
    .raddr (rd_addr),
    .rdata (rd_word)
  );

  assign rd_data = rd_word[DW-1:TS_W];
  assign rd_ts   = rd_word[TS_W-1:0];
  assign wr_ptr  = ptr_q;
  assign rec_cnt = cnt_q;
  assign full    = full_q;
endmodule

// File: rtl/trc_change_rec_chk.sv
module trc_change_rec_chk #(
  parameter int DEPTH = 32,
  parameter int TS_W  = 8,
  parameter int CW    = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            rec_en,
  input logic            en_q,
  input logic [TS_W-1:0] ts,
  input logic [CW-1:0]   rec_cnt,
  input logic            full
);
  // R8: count never exceeds depth
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    rec_cnt <= CW'(DEPTH));

  // R8: a full buffer stays full while capture stays enabled
  a_r8_full_hold: assert property (@(posedge clk) disable iff (rst)
    (full && en_q) |=> (rec_cnt == CW'(DEPTH)));

  // R7: disabled capture leaves the count untouched
  a_r7_no_write_off: assert property (@(posedge clk) disable iff (rst)
    !rec_en |=> $stable(rec_cnt));

  // R1: arming restarts the run
  a_r1_arm_restart: assert property (@(posedge clk) disable iff (rst)
    (rec_en && !en_q) |=> (rec_cnt <= CW'(1)));

  // R6: at most one record per cycle, even when forced and change stores coincide
  a_r6_one_per_cycle: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rec_cnt == $past(rec_cnt) || rec_cnt == $past(rec_cnt) + 1'b1 || rec_cnt <= CW'(1)));

  // R5: timestamp advances by one each clock
  a_r5_ts_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ts == TS_W'($past(ts) + 1'b1)));

  // R8: full flag agrees with the count
  a_r8_full_flag: assert property (@(posedge clk) disable iff (rst)
    full == (rec_cnt == CW'(DEPTH)));
endmodule

bind trc_change_rec trc_change_rec_chk #(
  .DEPTH (DEPTH),
  .TS_W  (TS_W),
  .CW    (CW)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .rec_en  (rec_en),
  .en_q    (en_q),
  .ts      (ts),
  .rec_cnt (rec_cnt),
  .full    (full)
);

// File: tb/tb_trc_change_rec.sv
module tb_trc_change_rec;
  localparam int PER   = 10;
  localparam int CH    = 16;
  localparam int NGRP  = 2;
  localparam int GW    = CH / NGRP;
  localparam int DEPTH = 32;
  localparam int TS_W  = 8;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = AW + 1;
  localparam int DW    = CH + TS_W;

  logic            clk = 1'b0;
  logic            rst;
  logic            rec_en;
  logic [NGRP-1:0] smp_vld;
  logic [CH-1:0]   smp_data;
  logic [2*CH-1:0] det_cfg;
  logic [AW-1:0]   rd_addr;
  logic [CH-1:0]   rd_data;
  logic [TS_W-1:0] rd_ts;
  logic [AW-1:0]   wr_ptr;
  logic [CW-1:0]   rec_cnt;
  logic            full;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(PER/2) clk = ~clk;

  trc_change_rec #(.CH(CH), .NGRP(NGRP), .DEPTH(DEPTH), .TS_W(TS_W)) dut (
    .clk (clk), .rst (rst), .rec_en (rec_en), .smp_vld (smp_vld),
    .smp_data (smp_data), .det_cfg (det_cfg), .rd_addr (rd_addr),
    .rd_data (rd_data), .rd_ts (rd_ts), .wr_ptr (wr_ptr),
    .rec_cnt (rec_cnt), .full (full)
  );

  // reference model built from the requirements
  logic [DW-1:0]   exp_q[$];
  logic [TS_W-1:0] m_ts;
  logic [CH-1:0]   m_held;
  bit              m_enq, m_ref;
  int              m_cnt;

  function automatic bit rule_hit(logic [1:0] r, logic p, logic n);
    case (r)
      2'b01:   return p != n;
      2'b10:   return !p && n;
      2'b11:   return p && !n;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [CH-1:0] nxt;
    bit chg;
    if (rst) begin
      m_ts = '0; m_held = '0; m_enq = 0; m_ref = 0; m_cnt = 0;
      exp_q.delete();
    end else begin
      if (rec_en && !m_enq) begin exp_q.delete(); m_cnt = 0; end
      nxt = m_held; chg = 0;
      for (int g = 0; g < NGRP; g++)
        if (smp_vld[g])
          for (int c = g*GW; c < (g+1)*GW; c++) begin
            chg |= rule_hit(det_cfg[2*c +: 2], m_held[c], smp_data[c]);
            nxt[c] = smp_data[c];
          end
      if (rec_en && m_cnt < DEPTH &&
          (((|smp_vld) && (!m_ref || chg)) || ((&m_ts) && m_ref))) begin
        exp_q.push_back({nxt, m_ts});
        m_cnt++;
      end
      m_ref  = rec_en && (m_ref || (|smp_vld));
      m_held = nxt;
      m_enq  = rec_en;
      m_ts   = m_ts + 1'b1;
    end
  end

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic smp(logic [NGRP-1:0] v, logic [CH-1:0] d);
    @(negedge clk); smp_vld = v; smp_data = d;
    @(negedge clk); smp_vld = '0;
  endtask

  task automatic arm();
    @(negedge clk); rec_en = 0;
    @(negedge clk); rec_en = 1;
  endtask

  // R9 read-back of every expected record, with capture stopped
  task automatic compare_all(string req);
    @(negedge clk); rec_en = 0; smp_vld = '0;
    @(negedge clk);
    check({req, " count"}, 64'(rec_cnt), 64'(exp_q.size()));
    for (int i = 0; i < exp_q.size(); i++) begin
      rd_addr = AW'(i);
      @(negedge clk);
      check({req, " R9 record"}, 64'({rd_data, rd_ts}), 64'(exp_q[i]));
    end
  endtask

  initial begin
    int n0;
    logic [CH-1:0] d;
    void'($urandom(32'd20240611));
    rst = 1; rec_en = 0; smp_vld = '0; smp_data = '0; det_cfg = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R10 rec_cnt", 64'(rec_cnt), 0);
    check("R10 wr_ptr", 64'(wr_ptr), 0);
    check("R10 full", 64'(full), 0);

    // R2 directed rules: ch0 any, ch1 rise, ch2 fall, ch3 ignore
    det_cfg = '0;
    det_cfg[1:0] = 2'b01; det_cfg[3:2] = 2'b10; det_cfg[5:4] = 2'b11; det_cfg[7:6] = 2'b00;
    arm();
    smp(2'b01, 16'h0000);
    check("R1 reference", 64'(rec_cnt), 1);
    smp(2'b01, 16'h0008);
    check("R2 ignore ch", 64'(rec_cnt), 1);
    smp(2'b01, 16'h000A);
    check("R2 rise", 64'(rec_cnt), 2);
    smp(2'b01, 16'h0008);
    check("R2 rise-only ignores fall", 64'(rec_cnt), 2);
    smp(2'b01, 16'h000C);
    check("R2 fall-only ignores rise", 64'(rec_cnt), 2);
    smp(2'b01, 16'h0008);
    smp(2'b01, 16'h0009);
    check("R2 fall and any", 64'(rec_cnt), 4);
    compare_all("R2 R3");

    // R4 group hold
    det_cfg = {2*CH{1'b0}} | {CH{2'b01}};
    arm();
    smp(2'b11, 16'h1234);
    smp(2'b10, 16'h12FF);
    check("R4 unstrobed group", 64'(rec_cnt), 1);
    smp(2'b10, 16'h56FF);
    check("R4 strobed group", 64'(rec_cnt), 2);
    compare_all("R4 R3");

    // R6 coincidence of forced and change store
    arm();
    smp(2'b11, 16'h0000);
    while (m_ts != '1) @(negedge clk);
    n0 = exp_q.size();
    smp_vld = 2'b01; smp_data = 16'h0001;
    @(negedge clk); smp_vld = '0;
    check("R6 single record", 64'(rec_cnt), 64'(n0 + 1));
    check("R6 R5 ts top", 64'(exp_q[exp_q.size()-1][TS_W-1:0]), 64'(8'hFF));
    repeat (600) @(negedge clk);
    check("R6 forced quiet", 64'(rec_cnt), 64'(n0 + 3));
    compare_all("R6 R5");

    // R7 disabled capture
    @(negedge clk); rec_en = 0;
    n0 = rec_cnt;
    smp(2'b11, 16'hFFFF);
    smp(2'b11, 16'h0F0F);
    check("R7 no write", 64'(rec_cnt), 64'(n0));

    // random mix with random rules
    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < CH; c++) det_cfg[2*c +: 2] = 2'($urandom_range(0, 3));
      arm();
      d = smp_data;
      for (int i = 0; i < 120; i++) begin
        @(negedge clk);
        if ($urandom_range(0, 3) == 0) d[$urandom_range(0, CH-1)] ^= 1'b1;
        smp_vld  = NGRP'($urandom_range(0, 3));
        smp_data = d;
      end
      compare_all("R3 R2 R4 random");
    end

    // R8 fill past depth
    det_cfg = {CH{2'b01}};
    arm();
    for (int i = 0; i < DEPTH + 10; i++) begin
      @(negedge clk); smp_vld = 2'b11; smp_data = 16'(i);
    end
    @(negedge clk); smp_vld = '0;
    @(negedge clk);
    check("R8 count at depth", 64'(rec_cnt), DEPTH);
    check("R8 full", 64'(full), 1);
    compare_all("R8");

    // R1 re-arm restarts
    arm();
    @(negedge clk);
    check("R1 re-arm count", 64'(rec_cnt), 0);
    check("R1 re-arm full", 64'(full), 0);
    smp(2'b01, 16'h0000);
    check("R1 reference after re-arm", 64'(rec_cnt), 1);
    compare_all("R1");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PER * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule